// File: doc/BRIEF.md
# Four-Port Shared Word Memory with Collision Detection

This block is a word memory shared by four ports. Each port issues at most one access per cycle of the array clock. An access is either a read or a write of one 18-bit word at an address of `ADDR_W` bits. A per-port request strobe lets each port advance at its own rate, and read data comes out of a register at the port. Any number of ports may read one word in the same cycle. A write to a word that another port reads or writes in that same cycle is a collision. The block flags a collision on every port that takes part in it. It also resolves the collision in a fixed way, so the result never depends on simulation order.

Each port has a pair of chip enables. `ce_off_i` is active high and `ce_on_i` is active low. If either one is in its disabling state for a cycle, the port powers down. Its read data is then forced to zero and its valid output is dropped. After that, the port needs one full cycle with both enables asserted before it accepts requests again. The full array size of 64K words is reached with `ADDR_W = 16`. The default is smaller so that elaboration stays light.

Top module: `qport_ram`

## Requirements
- R1: A read accepted at a clock edge drives the stored word on `rdata_o` and raises `rvalid_o` for that port after that same edge. `rvalid_o` is low in every cycle that does not follow an accepted read.
- R2: Reads of the same address from several ports in one cycle all return the stored word. They raise no collision flag.
- R3: When two or more ports write the same address in one cycle, the word from the lowest-numbered of those ports is stored. Every writing port gets its collision flag.
- R4: When one port reads an address that another port writes in the same cycle, both ports get their collision flag. The reader receives the word that was stored before the write.
- R5: Accesses to different addresses raise no collision flag, and every write in that cycle is stored.
- R6: `coll_o[p]` is high for exactly the one cycle after a colliding access accepted from port p. It is never high for a port that had no accepted request.
- R7: A cycle with `ce_off_i[p]` high or `ce_on_i[p]` low powers the port down. That cycle's request is ignored, and after that edge `rdata_o` is zero and `rvalid_o` is low.
- R8: The first cycle with both enables asserted after a power-down only wakes the port, and its request is ignored. Requests are accepted from the following cycle on.
- R9: While `rst_ni` is low, all `rdata_o` bits, `rvalid_o` and `coll_o` are zero, and every port is awake.
- R10: A write issued while the port is powered down or waking up leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Array clock shared by all ports |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_off_i | input | NUM_PORTS | Per-port enable, active high disables |
| ce_on_i | input | NUM_PORTS | Per-port enable, active low disables |
| req_i | input | NUM_PORTS | Per-port access strobe |
| we_i | input | NUM_PORTS | Per-port write (1) or read (0) |
| addr_i | input | NUM_PORTS*ADDR_W | Addresses, port p in bits [p*ADDR_W +: ADDR_W] |
| wdata_i | input | NUM_PORTS*DATA_W | Write words, port p in bits [p*DATA_W +: DATA_W] |
| rdata_o | output | NUM_PORTS*DATA_W | Registered read words, same packing |
| rvalid_o | output | NUM_PORTS | Read data valid |
| coll_o | output | NUM_PORTS | One-cycle collision flag |

## Verification
The hardest cases to reach are a collision that has to land in a single cycle and a request that falls exactly on the wake-up cycle after a power-down. The bench drives all four ports from one task between clock edges, so two ports can aim at one address in the very same cycle. It then reads the word back through an uninvolved port. For the enables, it holds a request active across the down cycle and the wake cycle and checks which of the two cycles yields valid data. It also writes a known word beforehand, so that a write ignored during the down or wake cycle can be detected through another port.

// File: rtl/qport_pkg.sv
package qport_pkg;
  localparam int unsigned PORTS_DEF  = 4;
  localparam int unsigned ADDR_W_DEF = 10;
  localparam int unsigned DATA_W_DEF = 18;
endpackage

// File: rtl/qport_array.sv
module qport_array #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 18
) (
  input  logic                          clk_i,
  input  logic [NUM_PORTS-1:0]          wr_en_i,
  input  logic [NUM_PORTS*ADDR_W-1:0]   addr_i,
  input  logic [NUM_PORTS*DATA_W-1:0]   wdata_i,
  output logic [NUM_PORTS*DATA_W-1:0]   rword_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // highest index first: the lowest port's write is the last to land
  always_ff @(posedge clk_i) begin
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (wr_en_i[p]) mem_q[addr_i[p*ADDR_W +: ADDR_W]] <= wdata_i[p*DATA_W +: DATA_W];
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
    assign rword_o[g*DATA_W +: DATA_W] = mem_q[addr_i[g*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/qport_port.sv
module qport_port #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_off_i,
  input  logic              ce_on_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] rword_i,
  output logic              acc_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic              ce_ok;
  logic              awake_q;
  logic              rd_acc;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign ce_ok  = !ce_off_i && ce_on_i;
  assign acc_o  = req_i && ce_ok && awake_q;
  assign wr_o   = acc_o && we_i;
  assign rd_acc = acc_o && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      awake_q  <= 1'b1;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      awake_q  <= ce_ok;
      rvalid_q <= rd_acc;
      if (!ce_ok)      rdata_q <= '0;
      else if (rd_acc) rdata_q <= rword_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/qport_coll.sv
module qport_coll #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        acc_i,
  input  logic [NUM_PORTS-1:0]        we_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr_i,
  output logic [NUM_PORTS-1:0]        coll_o
);
  logic [NUM_PORTS-1:0] hit;
  logic [NUM_PORTS-1:0] coll_q;

  always_comb begin
    hit = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (q != p && acc_i[p] && acc_i[q] && (we_i[p] || we_i[q]) &&
            addr_i[p*ADDR_W +: ADDR_W] == addr_i[q*ADDR_W +: ADDR_W])
          hit[p] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coll_q <= '0;
    else         coll_q <= hit;
  end

  assign coll_o = coll_q;
endmodule

// File: rtl/qport_ram.sv
module qport_ram
  import qport_pkg::*;
#(
  parameter int unsigned NUM_PORTS = PORTS_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned DATA_W    = DATA_W_DEF
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PORTS-1:0]          ce_off_i,
  input  logic [NUM_PORTS-1:0]          ce_on_i,
  input  logic [NUM_PORTS-1:0]          req_i,
  input  logic [NUM_PORTS-1:0]          we_i,
  input  logic [NUM_PORTS*ADDR_W-1:0]   addr_i,
  input  logic [NUM_PORTS*DATA_W-1:0]   wdata_i,
  output logic [NUM_PORTS*DATA_W-1:0]   rdata_o,
  output logic [NUM_PORTS-1:0]          rvalid_o,
  output logic [NUM_PORTS-1:0]          coll_o
);
  logic [NUM_PORTS-1:0]        acc;
  logic [NUM_PORTS-1:0]        wr_en;
  logic [NUM_PORTS*DATA_W-1:0] rword;

  qport_array #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i   (clk_i),
    .wr_en_i (wr_en),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rword_o (rword)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    qport_port #(.DATA_W(DATA_W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ce_off_i (ce_off_i[g]),
      .ce_on_i  (ce_on_i[g]),
      .req_i    (req_i[g]),
      .we_i     (we_i[g]),
      .rword_i  (rword[g*DATA_W +: DATA_W]),
      .acc_o    (acc[g]),
      .wr_o     (wr_en[g]),
      .rdata_o  (rdata_o[g*DATA_W +: DATA_W]),
      .rvalid_o (rvalid_o[g])
    );
  end

  qport_coll #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_coll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .we_i   (we_i),
    .addr_i (addr_i),
    .coll_o (coll_o)
  );
endmodule

// File: rtl/qport_ram_chk.sv
module qport_ram_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 18
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_PORTS-1:0]          ce_off_i,
  input logic [NUM_PORTS-1:0]          ce_on_i,
  input logic [NUM_PORTS-1:0]          req_i,
  input logic [NUM_PORTS-1:0]          we_i,
  input logic [NUM_PORTS*ADDR_W-1:0]   addr_i,
  input logic [NUM_PORTS*DATA_W-1:0]   wdata_i,
  input logic [NUM_PORTS*DATA_W-1:0]   rdata_o,
  input logic [NUM_PORTS-1:0]          rvalid_o,
  input logic [NUM_PORTS-1:0]          coll_o
);
  logic [NUM_PORTS-1:0] wr_live;
  assign wr_live = req_i & we_i & ~ce_off_i & ce_on_i;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
    a_r1_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o[g] |-> $past(req_i[g] && !we_i[g] && !ce_off_i[g] && ce_on_i[g]));

    a_r7_down_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_off_i[g] || !ce_on_i[g]) |=> (!rvalid_o[g] && rdata_o[g*DATA_W +: DATA_W] == '0));

    a_r6_flag_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      coll_o[g] |-> $past(req_i[g] && !ce_off_i[g] && ce_on_i[g]));

    a_r2_flag_needs_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
      coll_o[g] |-> $past(|wr_live));
  end

  logic unused_ok;
  assign unused_ok = ^{addr_i, wdata_i};
endmodule

bind qport_ram qport_ram_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_off_i(ce_off_i), .ce_on_i(ce_on_i),
  .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o), .coll_o(coll_o)
);

// File: tb/qport_ram_tb.sv
module qport_ram_tb;
  localparam int NP = 4;
  localparam int AW = 10;
  localparam int DW = 18;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NP-1:0]   ce_off = '0;
  logic [NP-1:0]   ce_on = '1;
  logic [NP-1:0]   req = '0;
  logic [NP-1:0]   we = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*DW-1:0] wdata = '0;
  logic [NP*DW-1:0] rdata;
  logic [NP-1:0]   rvalid;
  logic [NP-1:0]   coll;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qport_ram u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_off_i(ce_off), .ce_on_i(ce_on),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .coll_o(coll)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    req = '0; we = '0;
  endtask

  task automatic put(input int p, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req[p] = 1'b1; we[p] = w;
    addr[p*AW +: AW] = a;
    wdata[p*DW +: DW] = d;
  endtask

  function automatic logic [DW-1:0] rd(input int p);
    return rdata[p*DW +: DW];
  endfunction

  task automatic t_reset();
    chk("R9 rvalid in reset", 32'(rvalid), 0);
    chk("R9 coll in reset", 32'(coll), 0);
    chk("R9 rdata in reset", 32'(|rdata), 0);
  endtask

  task automatic t_write_read();
    idle(); put(1, 1, 10'd10, 18'h2AAAA); cyc();
    chk("R1 no valid after write", 32'(rvalid[1]), 0);
    idle(); put(2, 0, 10'd10, '0); cyc();
    chk("R1 read data", 32'(rd(2)), 32'h2AAAA);
    chk("R1 read valid", 32'(rvalid[2]), 1);
    idle(); cyc();
    chk("R1 valid drops when idle", 32'(rvalid[2]), 0);
  endtask

  task automatic t_multi_read();
    idle();
    for (int p = 0; p < NP; p++) put(p, 0, 10'd10, '0);
    cyc();
    for (int p = 0; p < NP; p++) chk("R2 shared read data", 32'(rd(p)), 32'h2AAAA);
    chk("R2 no flag on read/read", 32'(coll), 0);
    chk("R2 all valid", 32'(rvalid), 32'hF);
  endtask

  task automatic t_write_write();
    idle(); put(1, 1, 10'd20, 18'h11111); put(3, 1, 10'd20, 18'h33333); cyc();
    chk("R3 flags on both writers", 32'(coll), 32'b1010);
    idle(); put(0, 0, 10'd20, '0); cyc();
    chk("R6 flag lasts one cycle", 32'(coll), 0);
    chk("R3 lowest port wins", 32'(rd(0)), 32'h11111);
  endtask

  task automatic t_read_write();
    idle(); put(0, 1, 10'd10, 18'h05555); put(2, 0, 10'd10, '0); cyc();
    chk("R4 flags reader and writer", 32'(coll), 32'b0101);
    chk("R4 reader sees old word", 32'(rd(2)), 32'h2AAAA);
    idle(); put(3, 0, 10'd10, '0); cyc();
    chk("R4 write landed", 32'(rd(3)), 32'h05555);
  endtask

  task automatic t_distinct();
    idle(); put(0, 1, 10'd30, 18'h00030); put(1, 1, 10'd31, 18'h00031); put(2, 0, 10'd20, '0); cyc();
    chk("R5 no flag on distinct addrs", 32'(coll), 0);
    idle(); put(2, 0, 10'd30, '0); put(3, 0, 10'd31, '0); cyc();
    chk("R5 write a stored", 32'(rd(2)), 32'h00030);
    chk("R5 write b stored", 32'(rd(3)), 32'h00031);
  endtask

  task automatic t_power();
    idle(); put(3, 0, 10'd10, '0); cyc();
    chk("R7 pre read", 32'(rd(3)), 32'h05555);
    ce_off[3] = 1'b1; cyc();
    chk("R7 down valid low", 32'(rvalid[3]), 0);
    chk("R7 down data zero", 32'(rd(3)), 0);
    ce_off[3] = 1'b0; cyc();
    chk("R8 wake cycle ignored", 32'(rvalid[3]), 0);
    cyc();
    chk("R8 accepted after wake", 32'(rvalid[3]), 1);
    chk("R8 data after wake", 32'(rd(3)), 32'h05555);
    idle(); ce_on[0] = 1'b0; put(0, 1, 10'd30, 18'h3FFFF); cyc();
    chk("R7 low enable drops port", 32'(rvalid[0]), 0);
    ce_on[0] = 1'b1; put(0, 1, 10'd31, 18'h3FFFF); cyc();
    idle(); put(1, 0, 10'd30, '0); put(2, 0, 10'd31, '0); cyc();
    chk("R10 write while down ignored", 32'(rd(1)), 32'h00030);
    chk("R10 write on wake cycle ignored", 32'(rd(2)), 32'h00031);
  endtask

  initial begin
    #20;
    t_reset();
    @(negedge clk); rst_ni = 1'b1;
    cyc();
    t_write_read();
    t_multi_read();
    t_write_write();
    t_read_write();
    t_distinct();
    t_power();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule